// File: doc/BRIEF.md
# Display Underflow Guard

This block sits between the pixel FIFOs and the raster outputs of four display heads. While a head's active-pixel strobe is high, the block takes one pixel from that head's FIFO. The FIFO is ready exactly when the strobe is high. If the FIFO has no pixel, the block puts out a substitute. The substitute depends on a per-head mode: either the last pixel that was output, or solid red. While the strobe is low, the head outputs black. Every output pixel is registered, so it appears one clock after the cycle that produced it.

Each head has a 32-bit control word on a simple memory-mapped bus, and the four words sit 0x800 bytes apart. The word holds three fields: a reporting enable, a sticky underflow flag, and the substitution mode. Substitution always follows the selected mode, whether reporting is on or off. The flag is recorded only while reporting is on, and software clears it by writing a one to it. A level output for each head follows that head's flag.

Inside each head, a three-state machine names the kind of pixel held in the output register:
- `ST_BLANK`: outside the active region.
- `ST_FLOW`: a real pixel was taken.
- `ST_STARVED`: a substitute was needed.

The transitions are chosen every clock from the current inputs:
- strobe low goes to `ST_BLANK`.
- strobe high with FIFO valid goes to `ST_FLOW`.
- strobe high with FIFO empty goes to `ST_STARVED`.

Any state can reach any other.

Top module: `uflow_guard`

## Requirements
- R1: After reset, every control word reads 0, every pixel output is 24'h000000, every status output is 0, and the read-data bus is 0.
- R2: Head h's word is at byte address BASE_OFS + h*0x800 (BASE_OFS defaults to 0x308). Bit 0 is the enable, bit 4 is the sticky flag and bit 8 is the mode. All other bits read 0 and ignore writes. A read of any other address returns 0, and a write to any other address changes nothing. Read data appears on the clock after the read strobe and holds until the next read.
- R3: `fifo_ready` equals the head's strobe. When the strobe and FIFO valid are both high, the next clock shows that FIFO data on the head's pixel output.
- R4: In mode 0, a starved active cycle outputs, one clock later, the last pixel taken from the FIFO. If no pixel has been taken since reset, that value is 24'h000000.
- R5: In mode 1, a starved active cycle outputs 24'hFF0000 one clock later.
- R6: Substitution follows the mode regardless of the enable bit.
- R7: A starved active cycle sets the flag on the next clock only if the enable was 1. With the enable at 0, the flag is never set.
- R8: Writing 1 to bit 4 clears the flag, and writing 0 to bit 4 leaves it unchanged. If an underflow and a clearing write land in the same cycle, the flag ends set.
- R9: Each head's status output equals its sticky flag.
- R10: A cycle with the strobe low outputs 24'h000000 one clock later and takes nothing from the FIFO.
- R11: Heads are independent. Traffic, register writes and underflows on one head do not affect any other head.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_wen | input | 1 | Register write strobe |
| bus_ren | input | 1 | Register read strobe |
| bus_addr | input | 13 | Byte address for reads and writes |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| pix_active | input | 4 | Active-pixel strobe, one bit per head |
| fifo_valid | input | 4 | FIFO holds a pixel, one bit per head |
| fifo_ready | output | 4 | Pixel taken this cycle, one bit per head |
| fifo_data | input | 96 | FIFO pixel data; head h uses bits 24h+23:24h, RGB888 |
| pix_out | output | 96 | Registered raster pixel; head h uses bits 24h+23:24h |
| uflow_stat | output | 4 | Sticky underflow flag, one bit per head |

## Verification
The assertions assume that reset is held for at least one clock and that every input is stable at the rising edge. They also assume a FIFO never withdraws a pixel in the cycle it is offered, since `fifo_ready` is taken to follow the strobe. The bench drives all inputs on the falling edge and derives every handshake from its own strobe. A pixel counts as consumed only when strobe and valid are both high, which matches what the guard assumes. Register traffic uses single-cycle strobes and never asserts read and write together, so the read-data timing the assertions rely on always holds.

// File: rtl/uflow_pkg.sv
package uflow_pkg;

    localparam int PIX_W = 24;

    typedef logic [PIX_W-1:0] pix_t;

    localparam pix_t PIX_RED   = 24'hFF0000;
    localparam pix_t PIX_BLACK = 24'h000000;

    // Field positions inside a head's control word.
    localparam int EN_BIT   = 0;
    localparam int FLAG_BIT = 4;
    localparam int MODE_BIT = 8;

    // Kind of pixel currently held in a head's output register.
    typedef enum logic [1:0] {
        ST_BLANK   = 2'd0,
        ST_FLOW    = 2'd1,
        ST_STARVED = 2'd2
    } out_st_e;

    function automatic logic [31:0] pack_word(input logic en, input logic flag, input logic mode);
        logic [31:0] w;
        w           = '0;
        w[EN_BIT]   = en;
        w[FLAG_BIT] = flag;
        w[MODE_BIT] = mode;
        return w;
    endfunction

endpackage

// File: rtl/uflow_head.sv
module uflow_head
    import uflow_pkg::*;
#(
    parameter int PW = PIX_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          active,
    input  logic          fvalid,
    input  logic [PW-1:0] fdata,
    input  logic          mode_red,
    output logic          fready,
    output logic          starve_evt,
    output logic [PW-1:0] pix
);

    localparam logic [PW-1:0] RED_V   = PW'(PIX_RED);
    localparam logic [PW-1:0] BLACK_V = '0;

    out_st_e       state_q, state_d;
    logic [PW-1:0] last_q;
    logic          red_q;

    assign fready     = active;
    assign starve_evt = active && !fvalid;

    // next-state selection
    always_comb begin
        if (!active) begin
            state_d = ST_BLANK;
        end else if (fvalid) begin
            state_d = ST_FLOW;
        end else begin
            state_d = ST_STARVED;
        end
    end

    // state register plus captured pixel and mode
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_BLANK;
            last_q  <= BLACK_V;
            red_q   <= 1'b0;
        end else begin
            state_q <= state_d;
            red_q   <= mode_red;
            if (active && fvalid) begin
                last_q <= fdata;
            end
        end
    end

    // output decode
    always_comb begin
        unique case (state_q)
            ST_BLANK:   pix = BLACK_V;
            ST_FLOW:    pix = last_q;
            ST_STARVED: pix = red_q ? RED_V : last_q;
            default:    pix = BLACK_V;
        endcase
    end

    a_r3_pass_through: assert property (@(posedge clk) disable iff (!rst_n)
        (active && fvalid) |=> (pix == $past(fdata)));

    a_r5_red_fill: assert property (@(posedge clk) disable iff (!rst_n)
        (active && !fvalid && mode_red) |=> (pix == RED_V));

    a_r4_repeat_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_STARVED && !red_q && active && !fvalid && !mode_red) |=> $stable(pix));

    a_r10_blank_out: assert property (@(posedge clk) disable iff (!rst_n)
        !active |=> (pix == BLACK_V));

endmodule

// File: rtl/uflow_csr.sv
module uflow_csr
    import uflow_pkg::*;
#(
    parameter int                    NH         = 4,
    parameter int                    AW         = 13,
    parameter int                    STRIDE_LSB = 11,
    parameter logic [STRIDE_LSB-1:0] BASE_OFS   = 'h308
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          bus_wen,
    input  logic          bus_ren,
    input  logic [AW-1:0] bus_addr,
    input  logic [31:0]   bus_wdata,
    output logic [31:0]   bus_rdata,
    input  logic [NH-1:0] evt,
    output logic [NH-1:0] en,
    output logic [NH-1:0] mode,
    output logic [NH-1:0] flag
);

    localparam int          IDX_W    = AW - STRIDE_LSB;
    localparam logic [31:0] RSV_MASK = ~((32'd1 << EN_BIT) | (32'd1 << FLAG_BIT) | (32'd1 << MODE_BIT));

    logic [IDX_W-1:0] a_idx;
    logic             a_ofs_hit;
    logic [NH-1:0]    hit;
    logic [NH-1:0]    en_q, mode_q, flag_q;
    logic [31:0]      rd_word;
    logic [31:0]      rdata_q;

    assign a_idx     = bus_addr[AW-1:STRIDE_LSB];
    assign a_ofs_hit = (bus_addr[STRIDE_LSB-1:0] == BASE_OFS);

    for (genvar h = 0; h < NH; h++) begin : g_word
        assign hit[h] = a_ofs_hit && (a_idx == IDX_W'(h));

        always_ff @(posedge clk) begin
            if (!rst_n) begin
                en_q[h]   <= 1'b0;
                mode_q[h] <= 1'b0;
                flag_q[h] <= 1'b0;
            end else begin
                if (bus_wen && hit[h]) begin
                    en_q[h]   <= bus_wdata[EN_BIT];
                    mode_q[h] <= bus_wdata[MODE_BIT];
                end
                if (evt[h] && en_q[h]) begin
                    flag_q[h] <= 1'b1;
                end else if (bus_wen && hit[h] && bus_wdata[FLAG_BIT]) begin
                    flag_q[h] <= 1'b0;
                end
            end
        end

        a_r7_no_record_when_off: assert property (@(posedge clk) disable iff (!rst_n)
            (!en_q[h] && !flag_q[h]) |=> !flag_q[h]);

        a_r8_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
            (evt[h] && en_q[h]) |=> flag_q[h]);
    end

    always_comb begin
        rd_word = '0;
        for (int h = 0; h < NH; h++) begin
            if (hit[h]) begin
                rd_word = pack_word(en_q[h], flag_q[h], mode_q[h]);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rdata_q <= '0;
        end else if (bus_ren) begin
            rdata_q <= rd_word;
        end
    end

    assign bus_rdata = rdata_q;
    assign en        = en_q;
    assign mode      = mode_q;
    assign flag      = flag_q;

    a_r2_reserved_zero: assert property (@(posedge clk) disable iff (!rst_n)
        bus_ren |=> ((bus_rdata & RSV_MASK) == 32'd0));

    a_r2_read_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_ren |=> $stable(bus_rdata));

endmodule

// File: rtl/uflow_guard.sv
module uflow_guard
    import uflow_pkg::*;
#(
    parameter int                    NH         = 4,
    parameter int                    PW         = PIX_W,
    parameter int                    AW         = 13,
    parameter int                    STRIDE_LSB = 11,
    parameter logic [STRIDE_LSB-1:0] BASE_OFS   = 'h308
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             bus_wen,
    input  logic             bus_ren,
    input  logic [AW-1:0]    bus_addr,
    input  logic [31:0]      bus_wdata,
    output logic [31:0]      bus_rdata,
    input  logic [NH-1:0]    pix_active,
    input  logic [NH-1:0]    fifo_valid,
    output logic [NH-1:0]    fifo_ready,
    input  logic [NH*PW-1:0] fifo_data,
    output logic [NH*PW-1:0] pix_out,
    output logic [NH-1:0]    uflow_stat
);

    logic [NH-1:0] evt, en, mode, flag;

    uflow_csr #(
        .NH        (NH),
        .AW        (AW),
        .STRIDE_LSB(STRIDE_LSB),
        .BASE_OFS  (BASE_OFS)
    ) i_csr (
        .clk      (clk),
        .rst_n    (rst_n),
        .bus_wen  (bus_wen),
        .bus_ren  (bus_ren),
        .bus_addr (bus_addr),
        .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata),
        .evt      (evt),
        .en       (en),
        .mode     (mode),
        .flag     (flag)
    );

    for (genvar h = 0; h < NH; h++) begin : g_head
        uflow_head #(.PW(PW)) i_head (
            .clk       (clk),
            .rst_n     (rst_n),
            .active    (pix_active[h]),
            .fvalid    (fifo_valid[h]),
            .fdata     (fifo_data[h*PW +: PW]),
            .mode_red  (mode[h]),
            .fready    (fifo_ready[h]),
            .starve_evt(evt[h]),
            .pix       (pix_out[h*PW +: PW])
        );

        a_r6_fill_ignores_enable: assert property (@(posedge clk) disable iff (!rst_n)
            (pix_active[h] && !fifo_valid[h] && mode[h] && !en[h]) |=> (pix_out[h*PW +: PW] == PW'(PIX_RED)));
    end

    assign uflow_stat = flag;

endmodule

// File: tb/test_uflow_guard.sv
module test_uflow_guard;

    localparam int NH = 4;
    localparam int PW = 24;
    localparam int AW = 13;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             bus_wen = 1'b0;
    logic             bus_ren = 1'b0;
    logic [AW-1:0]    bus_addr = '0;
    logic [31:0]      bus_wdata = '0;
    logic [31:0]      bus_rdata;
    logic [NH-1:0]    pix_active = '0;
    logic [NH-1:0]    fifo_valid = '0;
    logic [NH-1:0]    fifo_ready;
    logic [NH*PW-1:0] fifo_data = '0;
    logic [NH*PW-1:0] pix_out;
    logic [NH-1:0]    uflow_stat;

    always #5 clk = ~clk;

    uflow_guard i_uflow_guard (
        .clk(clk), .rst_n(rst_n), .bus_wen(bus_wen), .bus_ren(bus_ren),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .pix_active(pix_active), .fifo_valid(fifo_valid), .fifo_ready(fifo_ready),
        .fifo_data(fifo_data), .pix_out(pix_out), .uflow_stat(uflow_stat)
    );

    typedef struct {
        int          head;
        logic [23:0] pix;
        logic        stat;
        string       tag;
    } sb_item_t;

    sb_item_t sb[$];
    int  n_chk  = 0;
    int  n_fail = 0;
    bit  done   = 1'b0;

    logic        m_en[NH];
    logic        m_mode[NH];
    logic        m_flag[NH];
    logic [23:0] m_last[NH];
    logic [31:0] m_rdata;

    function automatic logic [AW-1:0] head_addr(input int h);
        return AW'(32'h308 + h * 32'h800);
    endfunction

    function automatic logic [31:0] model_word(input logic [AW-1:0] a);
        logic [31:0] w = '0;
        for (int h = 0; h < NH; h++) begin
            if (a == head_addr(h)) begin
                w[0] = m_en[h];
                w[4] = m_flag[h];
                w[8] = m_mode[h];
            end
        end
        return w;
    endfunction

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    // Monitor: pops expectations after each edge.
    always @(posedge clk) begin
        #1;
        while (sb.size() > 0) begin
            sb_item_t it;
            it = sb.pop_front();
            check($sformatf("%s head%0d pixel", it.tag, it.head), 32'(pix_out[it.head*PW +: PW]), 32'(it.pix));
            check($sformatf("R9 head%0d status", it.head), 32'(uflow_stat[it.head]), 32'(it.stat));
        end
    end

    // Driver: one clock with the inputs currently set; pushes expected results.
    task automatic cycle(input string ctx);
        logic [31:0] rd_exp;
        rd_exp = bus_ren ? model_word(bus_addr) : m_rdata;
        for (int h = 0; h < NH; h++) begin
            sb_item_t it;
            logic w;
            logic ev;
            logic [23:0] d;
            d  = fifo_data[h*PW +: PW];
            ev = pix_active[h] && !fifo_valid[h];
            check($sformatf("R3 %s head%0d ready", ctx, h), 32'(fifo_ready[h]), 32'(pix_active[h]));
            it.head = h;
            if (!pix_active[h]) begin
                it.pix = 24'h0;      it.tag = {ctx, " R10"};
            end else if (fifo_valid[h]) begin
                it.pix = d;          it.tag = {ctx, " R3"};
            end else if (m_mode[h]) begin
                it.pix = 24'hFF0000; it.tag = m_en[h] ? {ctx, " R5"} : {ctx, " R5 R6"};
            end else begin
                it.pix = m_last[h];  it.tag = m_en[h] ? {ctx, " R4"} : {ctx, " R4 R6"};
            end
            if (pix_active[h] && fifo_valid[h]) m_last[h] = d;
            w = bus_wen && (bus_addr == head_addr(h));
            if (ev && m_en[h]) m_flag[h] = 1'b1;
            else if (w && bus_wdata[4]) m_flag[h] = 1'b0;
            if (w) begin
                m_en[h]   = bus_wdata[0];
                m_mode[h] = bus_wdata[8];
            end
            it.stat = m_flag[h];
            sb.push_back(it);
        end
        m_rdata = rd_exp;
        @(posedge clk);
        @(negedge clk);
        check({ctx, " R2 read data"}, bus_rdata, m_rdata);
        bus_wen = 1'b0;
        bus_ren = 1'b0;
    endtask

    task automatic wr(input int h, input logic [31:0] d, input string ctx);
        bus_wen = 1'b1; bus_addr = head_addr(h); bus_wdata = d;
        cycle(ctx);
    endtask

    task automatic rd_chk(input int h, input logic [31:0] exp, input string ctx);
        bus_ren = 1'b1; bus_addr = head_addr(h);
        cycle(ctx);
        check({ctx, " word"}, bus_rdata, exp);
    endtask

    task automatic set_head(input int h, input logic a, input logic v, input logic [23:0] d);
        pix_active[h] = a;
        fifo_valid[h] = v;
        fifo_data[h*PW +: PW] = d;
    endtask

    initial begin
        for (int h = 0; h < NH; h++) begin
            m_en[h] = 0; m_mode[h] = 0; m_flag[h] = 0; m_last[h] = '0;
        end
        m_rdata = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 pixels", 32'(|pix_out), 32'd0);
        check("R1 status", 32'(uflow_stat), 32'd0);
        check("R1 rdata", bus_rdata, 32'd0);
        for (int h = 0; h < NH; h++) rd_chk(h, 32'h0, "R1 reset word");

        // R4: starve before any pixel gives black on head1
        set_head(1, 1, 0, 24'h0);
        cycle("R4 first starve");
        set_head(1, 0, 0, 24'h0);

        // R3 / R10 pass-through and blanking on head0
        set_head(0, 1, 1, 24'h123456); cycle("R3 pass a");
        set_head(0, 1, 1, 24'hABCDEF); cycle("R3 pass b");
        set_head(0, 0, 1, 24'h777777); cycle("R10 blank");
        set_head(0, 1, 1, 24'h0A0B0C); cycle("R3 pass c");
        // R4 repeat with enable off, R7 no record
        set_head(0, 1, 0, 24'h999999); cycle("R4 repeat 1");
        cycle("R4 repeat 2");
        set_head(0, 0, 0, 24'h0);
        rd_chk(0, 32'h0, "R7 flag not recorded");

        // R6: red with enable off
        wr(0, 32'h100, "R6 mode red");
        set_head(0, 1, 0, 24'h0); cycle("R6 red fill");
        set_head(0, 0, 0, 24'h0);
        rd_chk(0, 32'h100, "R7 still clear");

        // R7 / R9: enable and starve
        wr(0, 32'h101, "R7 enable");
        set_head(0, 1, 0, 24'h0); cycle("R7 starve");
        set_head(0, 0, 0, 24'h0);
        rd_chk(0, 32'h111, "R7 flag set");
        check("R9 status head0", 32'(uflow_stat[0]), 32'd1);

        // R8: W1C behaviour
        wr(0, 32'h101, "R8 write zero to flag");
        rd_chk(0, 32'h111, "R8 flag kept");
        wr(0, 32'h111, "R8 clear");
        rd_chk(0, 32'h101, "R8 flag cleared");
        set_head(0, 1, 0, 24'h0);
        wr(0, 32'h111, "R8 set wins");
        set_head(0, 0, 0, 24'h0);
        rd_chk(0, 32'h111, "R8 set won");

        // R2: reserved bits, unmapped addresses
        wr(2, 32'hFFFF_FFEF, "R2 all ones");
        rd_chk(2, 32'h101, "R2 reserved ignored");
        wr(2, 32'h0, "R2 write zero");
        rd_chk(2, 32'h0, "R2 disabled");
        bus_wen = 1'b1; bus_addr = 13'h0300; bus_wdata = 32'hFFFF_FFFF;
        cycle("R2 unmapped write");
        bus_ren = 1'b1; bus_addr = 13'h0300;
        cycle("R2 unmapped read");
        check("R2 unmapped word", bus_rdata, 32'h0);
        for (int h = 1; h < NH; h++) rd_chk(h, 32'h0, "R2 R11 untouched");

        // R11: mixed traffic on all heads
        wr(3, 32'h001, "R11 enable head3");
        for (int i = 0; i < 400; i++) begin
            for (int h = 0; h < NH; h++) begin
                set_head(h, ($urandom % 4) != 0, ($urandom % 3) != 0, 24'($urandom));
            end
            if (($urandom % 8) == 0) begin
                bus_wen = 1'b1; bus_addr = head_addr($urandom % NH);
                bus_wdata = $urandom & 32'h0000_0111;
            end else if (($urandom % 6) == 0) begin
                bus_ren = 1'b1; bus_addr = head_addr($urandom % NH);
            end
            cycle("R11 mixed");
        end
        pix_active = '0;
        cycle("R10 final blank");
        if (!done) begin
            done = 1'b1;
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_chk++; n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
            $finish;
        end
    end

endmodule